// File: doc/BRIEF.md
# Microphone Calibration Window Sequencer

This block schedules a two-channel microphone gain-matching calibration. A run begins on a rising edge of either the calibrate pin or the calibration bit held in a control register. The first source to rise owns the run, and the other source is locked out until the run ends. From that point the block counts millisecond ticks. It opens one measurement window per test tone in a fixed schedule: 1 kHz, then 300 Hz, then 3 kHz. Closed gaps separate the windows. Measurement samples are passed on only while a window is open.

When the count reaches the completion point, the block raises a done flag. If the program-enable input is high in that cycle, it also raises a one-cycle request to store the results in non-volatile memory. The owning source must stay high for the whole run. If it falls early, the run is abandoned and no store is requested. A single-tone mode opens only the 1 kHz window. The analog measurement and the coefficient arithmetic lie outside this block.

Top module: `cal_window_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `storeReq`, `sampleTake` and every bit of `winOpen` are 0. A source that is already high at reset does not start a run until it has fallen and risen again.
- R2: A 0-to-1 change of `calPin`, seen while the block is idle, sets `busy` from the next clock edge and restarts the elapsed-tick count at 0.
- R3: A 0-to-1 change of `regStart`, seen while the block is idle, starts a run in the same way. If both sources rise in the same cycle, the register bit owns the run.
- R4: During a run, rising edges on the source that does not own the run are ignored. They neither restart the elapsed count nor end the run.
- R5: With `n` counting the `msTick` cycles since the start, bit 0 of `winOpen` (1 kHz) is high for 10 <= n < 200, bit 1 (300 Hz) for 210 <= n < 400, and bit 2 (3 kHz) for 410 <= n < 600. `toneIdx` gives the index of the open window and is 0 when no window is open.
- R6: `sampleTake` equals `sampleValid` while a window is open and is 0 at all other times: in idle, before the first window, in the gaps between windows, and after the last window.
- R7: When n reaches 790 and the owning source is still high, `busy` falls and `done` rises on the next edge. `done` stays high until the owning source falls, and the block then returns to idle.
- R8: `storeReq` is a single-cycle pulse, asserted together with the rise of `done`, and only if `progEn` was high in the cycle in which the run completed.
- R9: If the owning source falls before completion, the block returns to idle on the next edge without raising `done` or `storeReq`.
- R10: While `oneTone` is high, only bit 0 of `winOpen` can open. Bits 1 and 2 stay 0 through the 300 Hz and 3 kHz slots.
- R11: After a run ends, a source that remains high does not start a new run. Only a fresh rising edge starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msTick | input | 1 | One-cycle pulse per elapsed millisecond |
| calPin | input | 1 | Calibrate pin level |
| regStart | input | 1 | Calibration control bit from the register file |
| progEn | input | 1 | Program-enable level; permits the store request |
| oneTone | input | 1 | Selects the single-tone (1 kHz only) schedule |
| sampleValid | input | 1 | Qualifier from the measurement path |
| winOpen | output | 3 | One bit per tone window, 1 = window open |
| toneIdx | output | 2 | Index of the open window (0: 1 kHz, 1: 300 Hz, 2: 3 kHz) |
| sampleTake | output | 1 | Qualified sample accepted for the open window |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed and start source still held |
| storeReq | output | 1 | One-cycle request to store the results |

## Verification
A corrupted elapsed count shows as a window edge that is off by some number of ticks at `winOpen`. The error becomes visible at the first window boundary after it occurs, so at most about 200 ticks later. A wrong owner, or a missed lockout, shows at `busy` within one cycle of the owning source being released or the foreign edge arriving. If that edge restarts the count, the error shows at the next window edge instead. A wrong completion decision shows at `done` and `storeReq` in the cycle after tick 790, or as a store pulse after an aborted run.

// File: rtl/cal_window_seq_pkg.sv
package cal_window_seq_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

  // Strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic clearCnt;  // restart the elapsed-tick count
    logic runCnt;    // run active: count ticks, windows may open
  } seqStrobe_t;

endpackage

// File: rtl/cal_window_seq_ctrl.sv
module cal_window_seq_ctrl
  import cal_window_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       calPin,
  input  logic       regStart,
  input  logic       progEn,
  input  logic       finished,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       storeReq
);

  seqState_t stateQ, stateD;
  logic srcIsRegQ, srcIsRegD;
  logic pinQ, regQ;
  logic pinRise, regRise, holdLevel;
  logic storeD;

  assign pinRise   = calPin & ~pinQ;
  assign regRise   = regStart & ~regQ;
  assign holdLevel = srcIsRegQ ? regStart : calPin;

  always_comb begin
    stateD          = stateQ;
    srcIsRegD       = srcIsRegQ;
    storeD          = 1'b0;
    strobe.clearCnt = 1'b0;
    strobe.runCnt   = (stateQ == ST_RUN);
    unique case (stateQ)
      ST_IDLE: begin
        if (regRise) begin
          stateD          = ST_RUN;
          srcIsRegD       = 1'b1;
          strobe.clearCnt = 1'b1;
        end else if (pinRise) begin
          stateD          = ST_RUN;
          srcIsRegD       = 1'b0;
          strobe.clearCnt = 1'b1;
        end
      end
      ST_RUN: begin
        if (!holdLevel) begin
          stateD = ST_IDLE;
        end else if (finished) begin
          stateD = ST_DONE;
          storeD = progEn;
        end
      end
      ST_DONE: begin
        if (!holdLevel) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      srcIsRegQ <= 1'b0;
      pinQ      <= 1'b1;  // a level already high at reset is not an edge
      regQ      <= 1'b1;
      storeReq  <= 1'b0;
    end else begin
      stateQ    <= stateD;
      srcIsRegQ <= srcIsRegD;
      pinQ      <= calPin;
      regQ      <= regStart;
      storeReq  <= storeD;
    end
  end

  assign busy = (stateQ == ST_RUN);
  assign done = (stateQ == ST_DONE);

endmodule

// File: rtl/cal_window_seq_timer.sv
module cal_window_seq_timer
  import cal_window_seq_pkg::*;
#(
  parameter int NUM_TONES  = 3,
  parameter int FIRST_OPEN = 10,
  parameter int WIN_LEN    = 190,
  parameter int WIN_PITCH  = 200,
  parameter int DONE_MS    = 790,
  parameter int CNT_W      = 10,
  parameter int IDX_W      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msTick,
  input  seqStrobe_t           strobe,
  input  logic                 oneTone,
  input  logic                 sampleValid,
  output logic                 finished,
  output logic [NUM_TONES-1:0] winOpen,
  output logic [IDX_W-1:0]     toneIdx,
  output logic                 sampleTake
);

  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(DONE_MS);

  logic [CNT_W-1:0] msCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCnt <= '0;
    end else if (strobe.clearCnt) begin
      msCnt <= '0;
    end else if (strobe.runCnt && msTick && (msCnt != DONE_CNT)) begin
      msCnt <= msCnt + 1'b1;
    end
  end

  assign finished = (msCnt == DONE_CNT);

  for (genvar k = 0; k < NUM_TONES; k++) begin : g_win
    localparam logic [CNT_W-1:0] OPEN_AT  = CNT_W'(FIRST_OPEN + k * WIN_PITCH);
    localparam logic [CNT_W-1:0] CLOSE_AT = CNT_W'(FIRST_OPEN + k * WIN_PITCH + WIN_LEN);
    logic inRange;
    assign inRange = strobe.runCnt && (msCnt >= OPEN_AT) && (msCnt < CLOSE_AT);
    if (k == 0) begin : g_first
      assign winOpen[k] = inRange;
    end else begin : g_later
      assign winOpen[k] = inRange && !oneTone;
    end
  end

  always_comb begin
    toneIdx = '0;
    for (int k = 0; k < NUM_TONES; k++) begin
      if (winOpen[k]) toneIdx = IDX_W'(k);
    end
  end

  assign sampleTake = sampleValid && (|winOpen);

endmodule

// File: rtl/cal_window_seq.sv
module cal_window_seq
  import cal_window_seq_pkg::*;
#(
  parameter int NUM_TONES  = 3,
  parameter int FIRST_OPEN = 10,
  parameter int WIN_LEN    = 190,
  parameter int WIN_PITCH  = 200,
  parameter int DONE_MS    = 790,
  localparam int CNT_W     = $clog2(DONE_MS + 1),
  localparam int IDX_W     = (NUM_TONES > 1) ? $clog2(NUM_TONES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msTick,
  input  logic                 calPin,
  input  logic                 regStart,
  input  logic                 progEn,
  input  logic                 oneTone,
  input  logic                 sampleValid,
  output logic [NUM_TONES-1:0] winOpen,
  output logic [IDX_W-1:0]     toneIdx,
  output logic                 sampleTake,
  output logic                 busy,
  output logic                 done,
  output logic                 storeReq
);

  seqStrobe_t strobe;
  logic finished;

  cal_window_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .calPin   (calPin),
    .regStart (regStart),
    .progEn   (progEn),
    .finished (finished),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .storeReq (storeReq)
  );

  cal_window_seq_timer #(
    .NUM_TONES  (NUM_TONES),
    .FIRST_OPEN (FIRST_OPEN),
    .WIN_LEN    (WIN_LEN),
    .WIN_PITCH  (WIN_PITCH),
    .DONE_MS    (DONE_MS),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) u_timer (
    .clk         (clk),
    .rstN        (rstN),
    .msTick      (msTick),
    .strobe      (strobe),
    .oneTone     (oneTone),
    .sampleValid (sampleValid),
    .finished    (finished),
    .winOpen     (winOpen),
    .toneIdx     (toneIdx),
    .sampleTake  (sampleTake)
  );

endmodule

// File: rtl/cal_window_seq_chk.sv
module cal_window_seq_chk #(
  parameter int NUM_TONES = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 progEn,
  input logic                 oneTone,
  input logic [NUM_TONES-1:0] winOpen,
  input logic                 sampleTake,
  input logic                 busy,
  input logic                 done,
  input logic                 storeReq
);

  // R5: at most one tone window open at a time
  a_r5_one_window: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winOpen));

  // R5: windows only open during a run
  a_r5_window_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (|winOpen) |-> busy);

  // R6: samples pass only through an open window
  a_r6_take_in_window: assert property (@(posedge clk) disable iff (!rstN)
    sampleTake |-> (|winOpen));

  // R7: running and finished are exclusive
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8: store request lasts one cycle
  a_r8_store_single: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  // R8: store only when program-enable was high at completion
  a_r8_store_needs_pe: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> $past(progEn));

  // R9: a store never appears without completion
  a_r9_store_with_done: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> (done && $rose(done)));

  // R10: single-tone mode keeps later windows shut
  a_r10_one_tone: assert property (@(posedge clk) disable iff (!rstN)
    oneTone |-> (winOpen[NUM_TONES-1:1] == '0));

endmodule

bind cal_window_seq cal_window_seq_chk #(.NUM_TONES(NUM_TONES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .progEn     (progEn),
  .oneTone    (oneTone),
  .winOpen    (winOpen),
  .sampleTake (sampleTake),
  .busy       (busy),
  .done       (done),
  .storeReq   (storeReq)
);

// File: tb/sim_cal_window_seq.sv
`timescale 1ns/1ps
module sim_cal_window_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, calPin = 1'b0, regStart = 1'b0, progEn = 1'b0;
  logic oneTone = 1'b0, sampleValid = 1'b0;
  logic [2:0] winOpen;
  logic [1:0] toneIdx;
  logic sampleTake, busy, done, storeReq;

  int checks = 0;
  int errors = 0;
  bit finishedRun = 1'b0;

  // reference model state, from the requirements
  int mState = 0;       // 0 idle, 1 run, 2 done
  int mCnt = 0;
  bit mSrcReg = 1'b0;
  bit mPrevPin = 1'b1, mPrevReg = 1'b1;
  bit mStore = 1'b0;
  int tickDen = 1;      // tick every tickDen-th step on average

  always #2.5 clk = ~clk;

  cal_window_seq u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .calPin(calPin),
    .regStart(regStart), .progEn(progEn), .oneTone(oneTone),
    .sampleValid(sampleValid), .winOpen(winOpen), .toneIdx(toneIdx),
    .sampleTake(sampleTake), .busy(busy), .done(done), .storeReq(storeReq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] expWin(int st, int cnt, bit one);
    logic [2:0] w = 3'b000;
    if (st == 1) begin
      if (cnt >= 10 && cnt < 200) w[0] = 1'b1;
      if (cnt >= 210 && cnt < 400 && !one) w[1] = 1'b1;
      if (cnt >= 410 && cnt < 600 && !one) w[2] = 1'b1;
    end
    return w;
  endfunction

  function automatic int expIdx(logic [2:0] w);
    if (w[2]) return 2;
    if (w[1]) return 1;
    return 0;
  endfunction

  // model next state from the inputs present before the edge
  task automatic modelEdge();
    bit pr = calPin && !mPrevPin;
    bit rr = regStart && !mPrevReg;
    bit hold = mSrcReg ? regStart : calPin;
    mStore = 1'b0;
    case (mState)
      0: if (rr) begin mState = 1; mSrcReg = 1; mCnt = 0; end
         else if (pr) begin mState = 1; mSrcReg = 0; mCnt = 0; end
      1: if (!hold) mState = 0;
         else if (mCnt == 790) begin mState = 2; mStore = progEn; end
         else if (msTick) mCnt++;
      default: if (!hold) mState = 0;
    endcase
    mPrevPin = calPin;
    mPrevReg = regStart;
  endtask

  // one clock: model, edge, compare all outputs
  task automatic step();
    logic [2:0] w;
    modelEdge();
    @(posedge clk);
    #1;
    w = expWin(mState, mCnt, oneTone);
    chk("R7 busy", int'(busy), int'(mState == 1));
    chk("R7 done", int'(done), int'(mState == 2));
    chk(oneTone ? "R10 winOpen" : "R5 winOpen", int'(winOpen), int'(w));
    chk("R5 toneIdx", int'(toneIdx), expIdx(w));
    chk("R6 sampleTake", int'(sampleTake), int'(sampleValid && (w != 0)));
    chk("R8 storeReq", int'(storeReq), int'(mStore));
    msTick = (tickDen <= 1) ? 1'b1 : (($urandom % tickDen) == 0);
    sampleValid = $urandom % 2;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic runToDone();
    for (int i = 0; i < 4000 && mState == 1; i++) step();
  endtask

  int seedv;

  initial begin
    seedv = $urandom(32'd20240611);
    calPin = 1'b1;               // high through reset: must not start (R1)
    #12 rstN = 1'b1;
    #1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 winOpen", int'(winOpen), 0);
    chk("R1 storeReq", int'(storeReq), 0);
    steps(5);
    chk("R1 no start from reset level", int'(busy), 0);
    calPin = 1'b0;
    steps(3);

    // R2 pin start, full three-tone run with store
    progEn = 1'b1;
    calPin = 1'b1;
    step();
    chk("R2 pin start", int'(busy), 1);
    runToDone();
    chk("R8 done after full run", int'(done), 1);
    steps(20);
    chk("R7 done held", int'(done), 1);
    calPin = 1'b0;
    step();
    chk("R7 idle after release", int'(done), 0);
    steps(3);

    // R3 register start, R4 pin edges ignored, no store without PE
    progEn = 1'b0;
    regStart = 1'b1;
    step();
    chk("R3 reg start", int'(busy), 1);
    for (int i = 0; i < 300; i++) begin
      calPin = (i % 7) < 3;
      step();
    end
    chk("R4 run survives pin edges", int'(busy), 1);
    calPin = 1'b0;
    runToDone();
    chk("R8 done without PE", int'(done), 1);
    // R11 release owner while pin is high: no new run
    calPin = 1'b1;
    steps(2);
    regStart = 1'b0;
    steps(10);
    chk("R11 no restart on held pin", int'(busy), 0);
    calPin = 1'b0;
    steps(2);

    // R3 priority when both rise together, R9 abort
    progEn = 1'b1;
    calPin = 1'b1;
    regStart = 1'b1;
    steps(300);
    regStart = 1'b0;           // owner is register: abort
    step();
    chk("R9 abort to idle", int'(busy), 0);
    chk("R9 no store on abort", int'(storeReq), 0);
    steps(5);
    chk("R9 no done after abort", int'(done), 0);
    calPin = 1'b0;
    steps(2);

    // R10 single-tone run
    oneTone = 1'b1;
    calPin = 1'b1;
    runToDone();
    steps(2);
    runToDone();
    chk("R10 one-tone completes", int'(done), 1);
    calPin = 1'b0;
    oneTone = 1'b0;
    steps(3);

    // random runs: source, tick density, abort point, PE, mode
    for (int r = 0; r < 8; r++) begin
      int abortAt;
      bit useReg;
      tickDen = 1 + ($urandom % 3);
      useReg = $urandom % 2;
      progEn = $urandom % 2;
      oneTone = ($urandom % 4) == 0;
      abortAt = (($urandom % 3) == 0) ? int'($urandom % 700) : 100000;
      if (useReg) regStart = 1'b1; else calPin = 1'b1;
      for (int i = 0; i < 3000 && (mState != 2); i++) begin
        if (i == abortAt) begin regStart = 1'b0; calPin = 1'b0; end
        if (!useReg && (i % 50) == 5) regStart = ~regStart;  // foreign edges
        step();
        if (mState == 0 && i > 2) break;
      end
      regStart = 1'b0;
      calPin = 1'b0;
      steps(4);
      tickDen = 1;
    end

    finishedRun = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finishedRun) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule